// File: doc/BRIEF.md
# Vector Length Control Block Unit

This unit takes one compact vector-length control block, already split into its fields, and applies it to the architectural maximum vector length (MVL) and current vector length (VL) registers. It also produces, where the mode asks for it, a write of the resulting length into a destination integer register. The block carries a 2-bit mode, an immediate length, a destination index and a source index. One mode reads its requested length from the integer register file through a read port that the unit drives.

The unit owns the MVL and VL registers. Each accepted block is applied on a single clock edge. The new register values, the update strobes, the register-file write and the illegal flag all appear together in the following cycle. VL is never rounded to a value the hardware might prefer: it is the requested count, capped only by MVL. The reserved mode is a no-op when its fields are clear, and is reported as illegal otherwise.

Top module: `vlen_ctl_unit`

## Requirements
- R1: Mode 2'b00 sets VL to the smaller of the immediate and the current MVL, and leaves MVL unchanged.
- R2: In modes 2'b00 and 2'b10 the new VL, zero-extended, is written to the register named by the 5-bit rd field, unless that field is 0, in which case no register write occurs.
- R3: Mode 2'b10 sets both MVL and VL to the immediate in the same update.
- R4: Mode 2'b01 reads register 8 + rs1[2:0] and sets VL to the smaller of that value and MVL. It writes the result to register 8 + rd[2:0]. The register write always occurs in this mode, and the upper field bits are not used.
- R5: Mode 2'b11 with the immediate, rd and rs1 fields all zero has no effect: there are no strobes, no illegal flag and no register changes.
- R6: Mode 2'b11 with any nonzero field raises the illegal flag for one cycle and leaves MVL, VL and the register file untouched.
- R7: When the requested count is at most MVL, VL equals it exactly. This includes a request of zero, which is not an error.
- R8: A block is applied only in a cycle with blk_valid high. Its results are visible in the next cycle, and the strobes are single-cycle pulses. With blk_valid low, nothing changes.
- R9: After reset, MVL holds the parameter MVL_RST, VL holds 0, and every strobe and the illegal flag are low.
- R10: The register write, the VL strobe and the MVL strobe of one block are asserted in the same cycle, and rd_wdata equals the new VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | Block fields are valid this cycle |
| blk_mode | input | 2 | Block mode |
| blk_imm | input | LEN_W | Immediate length |
| blk_rd | input | 5 | Destination register field |
| blk_rs1 | input | 5 | Source register field |
| rf_raddr | output | 5 | Integer register file read address |
| rf_rdata | input | XLEN | Integer register file read data |
| mvl_we | output | 1 | MVL updated this cycle |
| mvl_q | output | LEN_W | Current MVL |
| vl_we | output | 1 | VL updated this cycle |
| vl_q | output | LEN_W | Current VL |
| rd_we | output | 1 | Integer register write strobe |
| rd_addr | output | 5 | Integer register write address |
| rd_wdata | output | XLEN | Integer register write data |
| illegal | output | 1 | Reserved mode with nonzero fields |

## Verification
Two functions can land in the same cycle: the integer register write, and the length-register update, which in mode 2'b10 updates MVL and VL together. The bench provokes this with random and directed blocks in modes 2'b00 and 2'b10 that name a nonzero rd. It then checks, in the cycle after acceptance, that all strobes the mode calls for are high together and that the written data equals the new VL. Blocks with rd equal to 0 check that the length update still happens while the write is suppressed.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  typedef enum logic [1:0] {
    VM_CAP  = 2'b00,
    VM_RS1  = 2'b01,
    VM_BOTH = 2'b10,
    VM_RSVD = 2'b11
  } vmode_e;

  localparam int REG_AW = 5;
  localparam int CMP_W  = 3;
  localparam logic [REG_AW-CMP_W-1:0] CMP_HI = 2'b01;
endpackage

// File: rtl/vlc_decode.sv
module vlc_decode
  import vlc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LEN_W = 7
) (
  input  logic [1:0]        mode,
  input  logic [LEN_W-1:0]  imm,
  input  logic [REG_AW-1:0] rd,
  input  logic [REG_AW-1:0] rs1,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [LEN_W-1:0]  mvl_cur,
  output logic [REG_AW-1:0] raddr,
  output logic              set_vl,
  output logic              set_mvl,
  output logic              wr_rd,
  output logic              bad,
  output logic [LEN_W-1:0]  new_vl,
  output logic [LEN_W-1:0]  new_mvl,
  output logic [REG_AW-1:0] rd_idx
);
  localparam int PAD_W = XLEN - LEN_W;

  function automatic logic [LEN_W-1:0] cap_imm(input logic [LEN_W-1:0] req,
                                               input logic [LEN_W-1:0] lim);
    return (req > lim) ? lim : req;
  endfunction

  function automatic logic [LEN_W-1:0] cap_reg(input logic [XLEN-1:0] req,
                                               input logic [LEN_W-1:0] lim);
    logic [XLEN-1:0] lim_w;
    lim_w = {{PAD_W{1'b0}}, lim};
    return (req > lim_w) ? lim : req[LEN_W-1:0];
  endfunction

  vmode_e mode_e;
  assign mode_e = vmode_e'(mode);
  assign raddr  = {CMP_HI, rs1[CMP_W-1:0]};

  always_comb begin
    set_vl  = 1'b0;
    set_mvl = 1'b0;
    wr_rd   = 1'b0;
    bad     = 1'b0;
    new_vl  = mvl_cur;
    new_mvl = mvl_cur;
    rd_idx  = rd;
    case (mode_e)
      VM_CAP: begin
        set_vl = 1'b1;
        new_vl = cap_imm(imm, mvl_cur);
        wr_rd  = (rd != '0);
      end
      VM_RS1: begin
        set_vl = 1'b1;
        new_vl = cap_reg(rs_val, mvl_cur);
        wr_rd  = 1'b1;
        rd_idx = {CMP_HI, rd[CMP_W-1:0]};
      end
      VM_BOTH: begin
        set_vl  = 1'b1;
        set_mvl = 1'b1;
        new_vl  = imm;
        new_mvl = imm;
        wr_rd   = (rd != '0);
      end
      default: bad = |{imm, rd, rs1};
    endcase
  end
endmodule

// File: rtl/vlc_commit.sv
module vlc_commit
  import vlc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int LEN_W   = 7,
  parameter int MVL_RST = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              set_vl,
  input  logic              set_mvl,
  input  logic              wr_rd,
  input  logic              bad,
  input  logic [LEN_W-1:0]  new_vl,
  input  logic [LEN_W-1:0]  new_mvl,
  input  logic [REG_AW-1:0] rd_idx,
  output logic              mvl_we,
  output logic [LEN_W-1:0]  mvl_q,
  output logic              vl_we,
  output logic [LEN_W-1:0]  vl_q,
  output logic              rd_we,
  output logic [REG_AW-1:0] rd_addr,
  output logic [XLEN-1:0]   rd_wdata,
  output logic              illegal
);
  localparam int PAD_W = XLEN - LEN_W;
  localparam logic [LEN_W-1:0] MVL_INIT = LEN_W'(MVL_RST);

  logic do_vl, do_mvl, do_rd, do_bad;
  assign do_vl  = valid & set_vl;
  assign do_mvl = valid & set_mvl;
  assign do_rd  = valid & wr_rd;
  assign do_bad = valid & bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mvl_q    <= MVL_INIT;
      vl_q     <= '0;
      mvl_we   <= 1'b0;
      vl_we    <= 1'b0;
      rd_we    <= 1'b0;
      illegal  <= 1'b0;
      rd_addr  <= '0;
      rd_wdata <= '0;
    end else begin
      mvl_we  <= do_mvl;
      vl_we   <= do_vl;
      rd_we   <= do_rd;
      illegal <= do_bad;
      if (do_vl)  vl_q  <= new_vl;
      if (do_mvl) mvl_q <= new_mvl;
      if (do_rd) begin
        rd_addr  <= rd_idx;
        rd_wdata <= {{PAD_W{1'b0}}, new_vl};
      end
    end
  end

  AST_VL_WITHIN_MVL: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= mvl_q); // R1
  AST_RD_NEVER_X0: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> rd_addr != '0); // R2
  AST_MVL_WITH_VL: assert property (@(posedge clk) disable iff (!rst_n)
    mvl_we |-> (vl_we && vl_q == mvl_q)); // R3
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!vl_we && !mvl_we && !rd_we && $stable(vl_q) && $stable(mvl_q))); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (!vl_we && !mvl_we && !rd_we && !illegal)); // R8
  AST_MVL_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !mvl_we |-> $stable(mvl_q)); // R8
  AST_RD_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (vl_we && rd_wdata == {{PAD_W{1'b0}}, vl_q})); // R10
endmodule

// File: rtl/vlen_ctl_unit.sv
module vlen_ctl_unit
  import vlc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int LEN_W   = 7,
  parameter int MVL_RST = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_valid,
  input  logic [1:0]        blk_mode,
  input  logic [LEN_W-1:0]  blk_imm,
  input  logic [REG_AW-1:0] blk_rd,
  input  logic [REG_AW-1:0] blk_rs1,
  output logic [REG_AW-1:0] rf_raddr,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              mvl_we,
  output logic [LEN_W-1:0]  mvl_q,
  output logic              vl_we,
  output logic [LEN_W-1:0]  vl_q,
  output logic              rd_we,
  output logic [REG_AW-1:0] rd_addr,
  output logic [XLEN-1:0]   rd_wdata,
  output logic              illegal
);
  logic              dec_set_vl, dec_set_mvl, dec_wr_rd, dec_bad;
  logic [LEN_W-1:0]  dec_vl, dec_mvl;
  logic [REG_AW-1:0] dec_rd;

  vlc_decode #(.XLEN(XLEN), .LEN_W(LEN_W)) u_dec (
    .mode    (blk_mode),
    .imm     (blk_imm),
    .rd      (blk_rd),
    .rs1     (blk_rs1),
    .rs_val  (rf_rdata),
    .mvl_cur (mvl_q),
    .raddr   (rf_raddr),
    .set_vl  (dec_set_vl),
    .set_mvl (dec_set_mvl),
    .wr_rd   (dec_wr_rd),
    .bad     (dec_bad),
    .new_vl  (dec_vl),
    .new_mvl (dec_mvl),
    .rd_idx  (dec_rd)
  );

  vlc_commit #(.XLEN(XLEN), .LEN_W(LEN_W), .MVL_RST(MVL_RST)) u_cmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (blk_valid),
    .set_vl   (dec_set_vl),
    .set_mvl  (dec_set_mvl),
    .wr_rd    (dec_wr_rd),
    .bad      (dec_bad),
    .new_vl   (dec_vl),
    .new_mvl  (dec_mvl),
    .rd_idx   (dec_rd),
    .mvl_we   (mvl_we),
    .mvl_q    (mvl_q),
    .vl_we    (vl_we),
    .vl_q     (vl_q),
    .rd_we    (rd_we),
    .rd_addr  (rd_addr),
    .rd_wdata (rd_wdata),
    .illegal  (illegal)
  );

  AST_RESERVED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_mode == 2'b11 && (|{blk_imm, blk_rd, blk_rs1})) |=> illegal); // R6
  AST_RESERVED_ZERO_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_mode == 2'b11 && !(|{blk_imm, blk_rd, blk_rs1}))
      |=> (!illegal && !vl_we && !mvl_we && !rd_we)); // R5
  AST_COMPACT_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_mode == 2'b01) |=> (rd_we && rd_addr[4:3] == 2'b01)); // R4
endmodule

// File: tb/vlen_ctl_unit_tb_top.sv
module vlen_ctl_unit_tb_top;
  localparam int XLEN = 32;
  localparam int LEN_W = 7;
  localparam int MVL_RST = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_valid = 1'b0;
  logic [1:0] blk_mode = '0;
  logic [LEN_W-1:0] blk_imm = '0;
  logic [4:0] blk_rd = '0, blk_rs1 = '0;
  logic [4:0] rf_raddr;
  logic [XLEN-1:0] rf_rdata;
  logic mvl_we, vl_we, rd_we, illegal;
  logic [LEN_W-1:0] mvl_q, vl_q;
  logic [4:0] rd_addr;
  logic [XLEN-1:0] rd_wdata;

  logic [XLEN-1:0] rf_m [32];
  assign rf_rdata = rf_m[rf_raddr];

  int n_chk = 0, n_bad = 0;
  int m_mvl = MVL_RST, m_vl = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vlen_ctl_unit #(.XLEN(XLEN), .LEN_W(LEN_W), .MVL_RST(MVL_RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_mode(blk_mode),
    .blk_imm(blk_imm), .blk_rd(blk_rd), .blk_rs1(blk_rs1),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .mvl_we(mvl_we), .mvl_q(mvl_q), .vl_we(vl_we), .vl_q(vl_q),
    .rd_we(rd_we), .rd_addr(rd_addr), .rd_wdata(rd_wdata), .illegal(illegal)
  );

  function automatic int smaller(longint req, int lim);
    return (req < longint'(lim)) ? int'(req) : lim;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_blk(bit v, logic [1:0] md, logic [LEN_W-1:0] im,
                         logic [4:0] rd, logic [4:0] rs, string req);
    int e_vl, e_mvl, e_addr;
    bit e_vwe, e_mwe, e_rwe, e_ill;
    e_vl = m_vl; e_mvl = m_mvl; e_addr = 0;
    e_vwe = 0; e_mwe = 0; e_rwe = 0; e_ill = 0;
    if (v) begin
      case (md)
        2'b00: begin e_vwe = 1; e_vl = smaller(longint'(im), m_mvl);
                     e_rwe = (rd != 0); e_addr = rd; end
        2'b01: begin e_vwe = 1; e_vl = smaller(longint'(rf_m[8 + rs[2:0]]), m_mvl);
                     e_rwe = 1; e_addr = 8 + rd[2:0]; end
        2'b10: begin e_vwe = 1; e_mwe = 1; e_vl = im; e_mvl = im;
                     e_rwe = (rd != 0); e_addr = rd; end
        default: e_ill = (im != 0) || (rd != 0) || (rs != 0);
      endcase
    end
    @(negedge clk);
    blk_valid = v; blk_mode = md; blk_imm = im; blk_rd = rd; blk_rs1 = rs;
    @(negedge clk);
    blk_valid = 1'b0;
    m_vl = e_vl; m_mvl = e_mvl;
    chk(vl_q == LEN_W'(e_vl), req, "vl", vl_q, e_vl);
    chk(mvl_q == LEN_W'(e_mvl), req, "mvl", mvl_q, e_mvl);
    chk(vl_we == e_vwe, req, "vl_we", vl_we, e_vwe);
    chk(mvl_we == e_mwe, req, "mvl_we", mvl_we, e_mwe);
    chk(illegal == e_ill, req, "illegal", illegal, e_ill);
    chk(rd_we == e_rwe, req, "rd_we", rd_we, e_rwe);
    if (e_rwe) begin
      chk(rd_addr == 5'(e_addr), req, "rd_addr", rd_addr, e_addr);
      chk(rd_wdata == XLEN'(e_vl), "R10", "rd_wdata", rd_wdata, e_vl);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) rf_m[i] = ($urandom % 2) ? ($urandom % 100) : $urandom;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(mvl_q == LEN_W'(MVL_RST), "R9", "mvl reset", mvl_q, MVL_RST);
    chk(vl_q == 0, "R9", "vl reset", vl_q, 0);
    chk(!(vl_we | mvl_we | rd_we | illegal), "R9", "strobes reset",
        {vl_we, mvl_we, rd_we, illegal}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 cap below and above MVL
    run_blk(1, 2'b00, 7'd20, 5'd3, 5'd0, "R1");
    run_blk(1, 2'b00, 7'd100, 5'd4, 5'd0, "R1");
    // R7 zero immediate
    run_blk(1, 2'b00, 7'd0, 5'd5, 5'd0, "R7");
    // R2 rd of zero suppresses the write
    run_blk(1, 2'b00, 7'd9, 5'd0, 5'd0, "R2");
    // R3 both registers, then R7 exact equal
    run_blk(1, 2'b10, 7'd40, 5'd7, 5'd0, "R3");
    run_blk(1, 2'b00, 7'd40, 5'd1, 5'd0, "R7");
    run_blk(1, 2'b00, 7'd41, 5'd1, 5'd0, "R1");
    run_blk(1, 2'b10, 7'd64, 5'd0, 5'd0, "R3");
    // R4 compact registers, big and small source
    rf_m[10] = 32'h8000_0000; rf_m[13] = 32'd17;
    run_blk(1, 2'b01, 7'd0, 5'd26, 5'd2, "R4");
    run_blk(1, 2'b01, 7'd0, 5'd0, 5'd29, "R4");
    // R5 and R6 reserved
    run_blk(1, 2'b11, 7'd0, 5'd0, 5'd0, "R5");
    run_blk(1, 2'b11, 7'd0, 5'd0, 5'd1, "R6");
    run_blk(1, 2'b11, 7'd3, 5'd0, 5'd0, "R6");
    // R8 not valid
    run_blk(0, 2'b10, 7'd5, 5'd6, 5'd0, "R8");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] md;
      bit v;
      v = ($urandom % 8) != 0;
      md = 2'($urandom);
      if (md == 2'b11 && ($urandom % 3) == 0)
        run_blk(v, md, '0, '0, '0, "R5");
      else
        run_blk(v, md, LEN_W'($urandom % 2 ? $urandom % 70 : $urandom),
                5'($urandom), 5'($urandom), v ? "R10" : "R8");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule